// File: doc/BRIEF.md
# Program Pulse Sequencer for On-Chip Programmable Memory

This block produces the control timing needed to write one byte into a programmable code memory or into its protection storage. The protection storage is the encryption table and the lock bits. A single-cycle start request captures three things: a 14-bit location, an 8-bit value and a target select. The block then presents the location and value on its address and data outputs. It drives the mode select and raises the high-voltage enable. It then sends a train of active-low program pulses and drops the voltage enable. After a final hold window, it reports completion with a one-clock done pulse.

All windows are counted in clock cycles. A parameter sets the number of cycles per microsecond, and its default suits a 6 MHz programming clock. With the defaults:
- each pulse is low for 600 cycles (100 us);
- the voltage lead, the voltage trail and the gaps between pulses are each 60 cycles (10 us);
- the address and data lead and trail are each 48 cycles.

A code-array write uses 5 pulses. A protection-storage write uses 25 pulses.

Top module: `prog_pulse_seq`

## Requirements
- R1: After reset, `busy` and `done` are 0, `vpp_en` is 0, `prog_n` is 1, and `addr_lo`, `addr_hi`, `data_out` and `mode_sel` are all 0.
- R2: When `start` is sampled high while the block is idle, the block captures the inputs and `busy` is 1 from the next cycle. Bits 7:0 of `addr` appear on `addr_lo`, bits 13:8 appear on `addr_hi`, and `wdata` appears on `data_out`. The target appears on `mode_sel`, where 0 selects the code array and 1 selects protection storage.
- R3: For the first 48 busy cycles, the address and data are presented while `vpp_en` is 0 and `prog_n` is 1.
- R4: `vpp_en` then rises and stays high for 60 cycles before `prog_n` first goes low.
- R5: Every program pulse holds `prog_n` low for exactly 600 cycles.
- R6: A write with target 0 emits 5 pulses, and a write with target 1 emits 25 pulses.
- R7: Consecutive pulses are separated by 60 cycles of `prog_n` high while `vpp_en` stays high.
- R8: After the last pulse rises, `vpp_en` stays high for 60 more cycles and then falls. The address and data then stay presented, with `busy` high, for a further 48 cycles.
- R9: `done` is then high for exactly one cycle with `busy` still 1, and `busy` is 0 on the following cycle.
- R10: A `start` seen while `busy` is 1 has no effect. This includes a `start` in the cycle where `done` is high. Such a request alters neither the captured outputs nor the sequence timing.
- R11: `prog_n` is low only while `vpp_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Programming clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin one byte write |
| target | input | 1 | 0 = code array, 1 = protection storage |
| addr | input | 14 | Location to write |
| wdata | input | 8 | Byte to write |
| addr_lo | output | 8 | Captured address bits 7:0 |
| addr_hi | output | 6 | Captured address bits 13:8 |
| data_out | output | 8 | Captured data byte |
| mode_sel | output | 1 | Captured target select |
| vpp_en | output | 1 | High-voltage enable |
| prog_n | output | 1 | Active-low program pulse |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Some properties hold on every cycle, and the embedded assertions check those:
- pulses occur only inside the voltage window, and the voltage never rises in the same cycle a pulse falls;
- every pulse has exactly the nominal width, and every pulse is preceded by at least the minimum high time;
- `done` is a single cycle that falls inside `busy`;
- the captured outputs stay frozen while a request arrives during `busy`.

The remaining behaviour needs the bench's scenarios:
- the exact lengths of the setup and trail windows;
- the pulse count for each target;
- the mapping of address bits onto the two output groups;
- that a request held high through the done cycle starts nothing until the block is idle again.

The bench builds the expected waveform of each write as a per-cycle queue and compares every output on every clock.

// File: rtl/prog_pulse_seq.sv
module prog_pulse_seq #(
  parameter int CLK_PER_US   = 6,
  parameter int PULSE_US     = 100,
  parameter int VSETUP_US    = 10,
  parameter int VHOLD_US     = 10,
  parameter int GAP_US       = 10,
  parameter int AD_SETUP_CYC = 48,
  parameter int AD_HOLD_CYC  = 48,
  parameter int MAIN_PULSES  = 5,
  parameter int PROT_PULSES  = 25
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        target,
  input  logic [13:0] addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  addr_lo,
  output logic [5:0]  addr_hi,
  output logic [7:0]  data_out,
  output logic        mode_sel,
  output logic        vpp_en,
  output logic        prog_n,
  output logic        busy,
  output logic        done
);
  localparam int PULSE_CYC  = CLK_PER_US * PULSE_US;
  localparam int VSETUP_CYC = CLK_PER_US * VSETUP_US;
  localparam int VHOLD_CYC  = CLK_PER_US * VHOLD_US;
  localparam int GAP_CYC    = CLK_PER_US * GAP_US;
  localparam int MIN_HIGH   = (GAP_CYC < VSETUP_CYC) ? GAP_CYC : VSETUP_CYC;
  localparam int CNT_W = $clog2(PULSE_CYC + VSETUP_CYC + VHOLD_CYC + GAP_CYC
                                + AD_SETUP_CYC + AD_HOLD_CYC + 1);
  localparam int PCNT_W = $clog2(MAIN_PULSES + PROT_PULSES + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_VRISE, S_PULSE, S_GAP, S_VHOLD, S_DHOLD, S_DONE
  } state_t;

  state_t              st;
  logic [CNT_W-1:0]    cnt;
  logic [PCNT_W-1:0]   left;
  logic [13:0]         lat_addr;
  logic [7:0]          lat_data;
  logic                lat_tgt;
  logic                tc;

  assign tc = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      left     <= '0;
      lat_addr <= '0;
      lat_data <= '0;
      lat_tgt  <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (start) begin
            st       <= S_SETUP;
            cnt      <= CNT_W'(AD_SETUP_CYC - 1);
            left     <= target ? PCNT_W'(PROT_PULSES) : PCNT_W'(MAIN_PULSES);
            lat_addr <= addr;
            lat_data <= wdata;
            lat_tgt  <= target;
          end
        end
        S_SETUP: if (tc) begin
          st  <= S_VRISE;
          cnt <= CNT_W'(VSETUP_CYC - 1);
        end
        S_VRISE: if (tc) begin
          st  <= S_PULSE;
          cnt <= CNT_W'(PULSE_CYC - 1);
        end
        S_PULSE: if (tc) begin
          left <= left - 1'b1;
          if (left == PCNT_W'(1)) begin
            st  <= S_VHOLD;
            cnt <= CNT_W'(VHOLD_CYC - 1);
          end else begin
            st  <= S_GAP;
            cnt <= CNT_W'(GAP_CYC - 1);
          end
        end
        S_GAP: if (tc) begin
          st  <= S_PULSE;
          cnt <= CNT_W'(PULSE_CYC - 1);
        end
        S_VHOLD: if (tc) begin
          st  <= S_DHOLD;
          cnt <= CNT_W'(AD_HOLD_CYC - 1);
        end
        S_DHOLD: if (tc) st <= S_DONE;
        default: begin
          st  <= S_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end

  assign vpp_en   = (st == S_VRISE) || (st == S_PULSE) || (st == S_GAP) || (st == S_VHOLD);
  assign prog_n   = (st != S_PULSE);
  assign busy     = (st != S_IDLE);
  assign done     = (st == S_DONE);
  assign addr_lo  = lat_addr[7:0];
  assign addr_hi  = lat_addr[13:8];
  assign data_out = lat_data;
  assign mode_sel = lat_tgt;

  logic [CNT_W-1:0] low_run;
  logic [CNT_W-1:0] high_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_run  <= '0;
      high_run <= '0;
    end else begin
      low_run  <= prog_n ? '0 : low_run + 1'b1;
      high_run <= (vpp_en && prog_n) ? high_run + 1'b1 : '0;
    end
  end

  assert_pulse_in_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> vpp_en);

  assert_vpp_leads_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vpp_en) |-> prog_n);

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_n) |-> (low_run == CNT_W'(PULSE_CYC)));

  assert_high_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_n) |-> (high_run >= CNT_W'(MIN_HIGH)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy ##1 (!done && !busy));

  assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(addr_lo) && $stable(addr_hi) && $stable(data_out)
                         && $stable(mode_sel)));
endmodule

// File: tb/tb_prog_pulse_seq.sv
module tb_prog_pulse_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        target = 1'b0;
  logic [13:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  addr_lo;
  logic [5:0]  addr_hi;
  logic [7:0]  data_out;
  logic        mode_sel, vpp_en, prog_n, busy, done;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  prog_pulse_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .target(target), .addr(addr),
    .wdata(wdata), .addr_lo(addr_lo), .addr_hi(addr_hi), .data_out(data_out),
    .mode_sel(mode_sel), .vpp_en(vpp_en), .prog_n(prog_n), .busy(busy), .done(done)
  );

  typedef struct packed {
    logic       b;
    logic       v;
    logic       p;
    logic       d;
    logic [3:0] tag;
  } exp_t;

  exp_t        expq[$];
  logic [13:0] e_addr = '0;
  logic [7:0]  e_data = '0;
  logic        e_tgt  = 1'b0;
  int          e_npul = 0;
  int          falls  = 0;
  logic        prev_p = 1'b1;

  function automatic string req_name(input logic [3:0] t);
    case (t)
      4'd1: return "R1";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd7: return "R7";
      4'd8: return "R8";
      4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic void push_n(input int n, input logic b, input logic v,
                                 input logic p, input logic d, input logic [3:0] t);
    for (int i = 0; i < n; i++) expq.push_back({b, v, p, d, t});
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      expq.delete();
    end else if (expq.size() != 0) begin
      void'(expq.pop_front());
    end else if (start) begin
      e_addr = addr;
      e_data = wdata;
      e_tgt  = target;
      e_npul = target ? 25 : 5;
      push_n(48, 1, 0, 1, 0, 4'd3);
      push_n(60, 1, 1, 1, 0, 4'd4);
      for (int k = 0; k < e_npul; k++) begin
        push_n(600, 1, 1, 0, 0, 4'd5);
        if (k < e_npul - 1) push_n(60, 1, 1, 1, 0, 4'd7);
      end
      push_n(60, 1, 1, 1, 0, 4'd8);
      push_n(48, 1, 0, 1, 0, 4'd8);
      push_n(1, 1, 0, 1, 1, 4'd9);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      exp_t e;
      e = (expq.size() != 0) ? expq[0] : exp_t'({1'b0, 1'b0, 1'b1, 1'b0, 4'd10});
      checks++;
      if ({busy, vpp_en, prog_n, done} !== {e.b, e.v, e.p, e.d}) begin
        fails++;
        $display("FAIL %s: busy/vpp/prog_n/done actual %b%b%b%b expected %b%b%b%b",
                 req_name(e.tag), busy, vpp_en, prog_n, done, e.b, e.v, e.p, e.d);
      end
      checks++;
      if ({addr_hi, addr_lo, data_out, mode_sel} !== {e_addr, e_data, e_tgt}) begin
        fails++;
        $display("FAIL R2/R10: addr/data/mode actual %h %h %b expected %h %h %b",
                 {addr_hi, addr_lo}, data_out, mode_sel, e_addr, e_data, e_tgt);
      end
      if (prev_p && !prog_n) falls++;
      prev_p = prog_n;
      if (done) begin
        checks++;
        if (falls != e_npul) begin
          fails++;
          $display("FAIL R6: pulse count actual %0d expected %0d", falls, e_npul);
        end
        falls = 0;
      end
    end
  end

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic wait_idle;
    do @(negedge clk); while (busy);
  endtask

  task automatic launch(input logic [13:0] a, input logic [7:0] d, input logic t);
    @(negedge clk);
    addr = a; wdata = d; target = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if ({busy, vpp_en, prog_n, done, addr_hi, addr_lo, data_out, mode_sel} !== {4'b0010, 23'd0}) begin
      fails++;
      $display("FAIL R1: reset outputs actual %b%b%b%b %h %h %b expected 0010 0 0 0",
               busy, vpp_en, prog_n, done, {addr_hi, addr_lo}, data_out, mode_sel);
    end

    // R2 R3 R4 R5 R6 R7 R8 R9: code-array write, R10: requests during busy
    launch(14'h2A5C, 8'hC3, 1'b0);
    repeat (1000) @(negedge clk);
    addr = 14'h1111; wdata = 8'h5A; target = 1'b1; start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (5) @(negedge clk);

    // R6: protection-storage write, 25 pulses
    launch(14'h003F, 8'h00, 1'b1);
    wait_idle();
    repeat (3) @(negedge clk);

    // R10: start held high through the done cycle; restart only from idle
    @(negedge clk);
    addr = 14'h3FFF; wdata = 8'hFF; target = 1'b0; start = 1'b1;
    @(negedge clk);
    addr = 14'h1000; wdata = 8'h81;
    wait_idle();
    do @(negedge clk); while (!busy);
    start = 1'b0;
    wait_idle();
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule